// File: doc/BRIEF.md
# Dual Down-Counter Timer and Port Register Block

This block is a byte-wide register file for a system controller. It holds two 16-bit down-counting timers, two 8-bit output ports with per-bit direction masks, a shift data byte, auxiliary and peripheral control bytes, and an interrupt flag and enable pair that drive one level interrupt line. A host reaches it over a simple synchronous bus. The register index is taken from address bits 12:9, and each access moves one byte. Read data is registered and appears on the cycle after the request. A tick enable input advances both timers by one count on each clock cycle in which it is high.

The first timer reloads itself from its latch when free-running, or fires once per load. The second timer only fires once per load. Writing a timer's high byte loads its counter. Reading a counter's low byte, or writing ones to the flag register, acknowledges the timer's interrupt. Writing the shift byte models a finished transfer and raises its flag. Reading the shift byte acknowledges that flag.

Top module: `dual_timer_regs`

## Requirements
- R1: After reset both latches and both counters hold 0xFFFF, the flags, enables, ports, directions and control bytes are 0, and irq is 0.
- R2: The index is bus_addr[12:9] (0 port B, 1 port A, 2 direction B, 3 direction A, 15 port A alias). A port write sets new = (old & ~dir) | (data & dir), and a read returns the stored byte.
- R3: Writes to index 4 or 6 change only the timer-1 latch low byte. A write to index 7 changes only the latch high byte and leaves the counter alone. Indices 6 and 7 read back the latch.
- R4: A write to index 5 sets the latch high byte and copies the whole latch into the timer-1 counter. Indices 4 and 5 read the counter low and high bytes.
- R5: With control byte (index 11) bits 7:6 = 01, timer 1 counts N, N-1, ..., 0, 0xFFFF, then reloads N. Flag bit 6 sets on every tick that takes 0 to 0xFFFF, giving a period of N+2 ticks.
- R6: With any other value of bits 7:6, timer 1 sets flag bit 6 only once per index-5 load, and the counter keeps decrementing past 0xFFFF with no reload.
- R7: Index 8 writes the timer-2 latch low byte. Index 9 writes the high byte and loads the counter. Timer 2 sets flag bit 5 once per load on its 0 to 0xFFFF tick. Indices 8 and 9 read its counter.
- R8: A flag-register read (index 13) returns the flags in bits 6:0 (6 T1, 5 T2, 4 shift clock, 3 shift data, 2 shift). Bit 7 is 1 when any flag is pending with its enable set.
- R9: An enable write (index 14) with data bit 7 = 1 sets the enables selected by data[6:0], and with bit 7 = 0 clears them. A read returns the enables with bit 7 = 1.
- R10: A write to index 10 stores the shift byte and sets flag bit 2. A read of index 10 returns the byte and clears flag bits 4, 3 and 2.
- R11: irq is registered and equals the OR of flags & enables over bits 6, 5 and 2, updating at the same edge as the flag or enable change.
- R12: A read of index 4 clears flag bit 6, a read of index 8 clears flag bit 5, and writing ones to index 13 clears those flags. A flag set in the same cycle as its clear stays set.
- R13: Index 11 and index 12 store and read back a byte each. A read returns the value a counter held before the edge on which the read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address, register index in bits 12:9 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| tick_en | input | 1 | Timer count enable, one count per high cycle |
| irq | output | 1 | Level interrupt request |
| pa_out | output | 8 | Port A data register |
| pa_dir | output | 8 | Port A direction mask |
| pb_out | output | 8 | Port B data register |
| pb_dir | output | 8 | Port B direction mask |

## Verification
A timer underflow and the host acknowledge of the same flag can fall in one cycle. The bench parks timer 1 at count 0 in free-running mode and then raises tick_en in the cycle that carries either a read of the low counter byte or a flag-register write with bit 6 set. The read must return 0x00, the pre-edge count. irq must then still be high, because the new event outranks the acknowledge, whereas the same clear one cycle away from an underflow drops irq.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [3:0] {
    IX_PB    = 4'd0,  IX_PA    = 4'd1,  IX_DIRB = 4'd2,  IX_DIRA = 4'd3,
    IX_T1CL  = 4'd4,  IX_T1CH  = 4'd5,  IX_T1LL = 4'd6,  IX_T1LH = 4'd7,
    IX_T2CL  = 4'd8,  IX_T2CH  = 4'd9,  IX_SHFT = 4'd10, IX_ACTL = 4'd11,
    IX_PCTL  = 4'd12, IX_FLAG  = 4'd13, IX_ENAB = 4'd14, IX_PANH = 4'd15
  } reg_ix_t;

  localparam int FLAG_W   = 7;
  localparam int FB_T1    = 6;
  localparam int FB_T2    = 5;
  localparam int FB_SCLK  = 4;
  localparam int FB_SDAT  = 3;
  localparam int FB_SHFT  = 2;
  localparam logic [FLAG_W-1:0] IRQ_MASK =
    (7'd1 << FB_T1) | (7'd1 << FB_T2) | (7'd1 << FB_SHFT);
  localparam logic [FLAG_W-1:0] SHIFT_ACK =
    (7'd1 << FB_SCLK) | (7'd1 << FB_SDAT) | (7'd1 << FB_SHFT);
endpackage

// File: rtl/dt_port.sv
module dt_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_we) data_q <= (data_q & ~dir_q) | (wdata & dir_q);
      if (dir_we)  dir_q  <= wdata;
    end
  end

  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (data_we && !dir_we) |=> (((data_q ^ $past(data_q)) & ~$past(dir_q)) == '0));
endmodule

// File: rtl/dt_timer.sv
module dt_timer #(
  parameter int CW       = 16,
  parameter bit CAN_CONT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cont_mode,
  input  logic          wr_lo,
  input  logic          wr_hi_load,
  input  logic          wr_hi_keep,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] latch_q,
  output logic          fire
);
  localparam int HB = CW - 8;
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  logic cont;
  logic armed_q;
  logic at_zero, at_ones;

  generate
    if (CAN_CONT) begin : g_cont
      assign cont = cont_mode;
    end else begin : g_oneshot
      assign cont = 1'b0;
    end
  endgenerate

  assign at_zero = (cnt_q == '0);
  assign at_ones = (cnt_q == ALL1);
  assign fire    = tick && !wr_hi_load && at_zero && (armed_q || cont);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= ALL1;
      cnt_q   <= ALL1;
      armed_q <= 1'b0;
    end else begin
      if (wr_lo) latch_q[7:0] <= wdata;
      if (wr_hi_load || wr_hi_keep) latch_q[CW-1:HB] <= wdata;
      if (wr_hi_load) begin
        cnt_q   <= {wdata, latch_q[7:0]};
        armed_q <= 1'b1;
      end else if (tick) begin
        if (at_ones && cont) cnt_q <= latch_q;
        else                 cnt_q <= cnt_q - 1'b1;
        if (at_zero) armed_q <= 1'b0;
      end
    end
  end

  // R4
  load_from_latch_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hi_load |=> (cnt_q == latch_q));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_hi_load && !wr_lo && at_ones && cont) |=> (cnt_q == latch_q));
  // R3
  latch_keep_count_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hi_keep && !tick && !wr_hi_load) |=> $stable(cnt_q));
endmodule

// File: rtl/dt_intc.sv
module dt_intc #(
  parameter int NF = 7,
  parameter logic [NF-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic          en_we,
  input  logic [7:0]    wdata,
  output logic [NF-1:0] flags_q,
  output logic [NF-1:0] en_q,
  output logic          irq_q
);
  logic [NF-1:0] flags_d, en_d;

  always_comb begin
    flags_d = (flags_q & ~clr_vec) | set_vec;
    en_d    = en_q;
    if (en_we) begin
      if (wdata[7]) en_d = en_q | wdata[NF-1:0];
      else          en_d = en_q & ~wdata[NF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
      irq_q   <= |(flags_d & en_d & MASK);
    end
  end

  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flags_q & en_q & MASK));
  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
  // R9
  enable_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en_we && wdata[7]) |=> ((en_q & $past(wdata[NF-1:0])) == $past(wdata[NF-1:0])));
endmodule

// File: rtl/dual_timer_regs.sv
module dual_timer_regs #(
  parameter int AW      = 13,
  parameter int IDX_LSB = 9,
  parameter int CW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          tick_en,
  output logic          irq,
  output logic [7:0]    pa_out,
  output logic [7:0]    pa_dir,
  output logic [7:0]    pb_out,
  output logic [7:0]    pb_dir
);
  import dt_pkg::*;

  localparam int HB = CW - 8;

  reg_ix_t ix;
  logic wr, rd;
  logic [7:0] shift_q, actl_q, pctl_q, rdata_d;
  logic [CW-1:0] t1_cnt, t1_lat, t2_cnt, t2_lat;
  logic t1_fire, t2_fire, t1_cont;
  logic [FLAG_W-1:0] flags, enables, set_vec, clr_vec;

  assign ix = reg_ix_t'(bus_addr[IDX_LSB +: 4]);
  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;
  assign t1_cont = (actl_q[7:6] == 2'b01);

  dt_port #(.W(8)) u_port_b (
    .clk(clk), .rst(rst),
    .data_we(wr && ix == IX_PB), .dir_we(wr && ix == IX_DIRB),
    .wdata(bus_wdata), .data_q(pb_out), .dir_q(pb_dir));

  dt_port #(.W(8)) u_port_a (
    .clk(clk), .rst(rst),
    .data_we(wr && (ix == IX_PA || ix == IX_PANH)), .dir_we(wr && ix == IX_DIRA),
    .wdata(bus_wdata), .data_q(pa_out), .dir_q(pa_dir));

  dt_timer #(.CW(CW), .CAN_CONT(1'b1)) u_t1 (
    .clk(clk), .rst(rst), .tick(tick_en), .cont_mode(t1_cont),
    .wr_lo(wr && (ix == IX_T1CL || ix == IX_T1LL)),
    .wr_hi_load(wr && ix == IX_T1CH),
    .wr_hi_keep(wr && ix == IX_T1LH),
    .wdata(bus_wdata), .cnt_q(t1_cnt), .latch_q(t1_lat), .fire(t1_fire));

  dt_timer #(.CW(CW), .CAN_CONT(1'b0)) u_t2 (
    .clk(clk), .rst(rst), .tick(tick_en), .cont_mode(1'b0),
    .wr_lo(wr && ix == IX_T2CL),
    .wr_hi_load(wr && ix == IX_T2CH),
    .wr_hi_keep(1'b0),
    .wdata(bus_wdata), .cnt_q(t2_cnt), .latch_q(t2_lat), .fire(t2_fire));

  always_comb begin
    set_vec = '0;
    set_vec[FB_T1]   = t1_fire;
    set_vec[FB_T2]   = t2_fire;
    set_vec[FB_SHFT] = wr && ix == IX_SHFT;
    clr_vec = '0;
    if (rd && ix == IX_SHFT) clr_vec = clr_vec | SHIFT_ACK;
    if (rd && ix == IX_T1CL) clr_vec[FB_T1] = 1'b1;
    if (rd && ix == IX_T2CL) clr_vec[FB_T2] = 1'b1;
    if (wr && ix == IX_FLAG) clr_vec = clr_vec | bus_wdata[FLAG_W-1:0];
  end

  dt_intc #(.NF(FLAG_W), .MASK(IRQ_MASK)) u_intc (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_we(wr && ix == IX_ENAB), .wdata(bus_wdata),
    .flags_q(flags), .en_q(enables), .irq_q(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      actl_q  <= '0;
      pctl_q  <= '0;
    end else if (wr) begin
      if (ix == IX_SHFT) shift_q <= bus_wdata;
      if (ix == IX_ACTL) actl_q  <= bus_wdata;
      if (ix == IX_PCTL) pctl_q  <= bus_wdata;
    end
  end

  always_comb begin
    unique case (ix)
      IX_PB:   rdata_d = pb_out;
      IX_PA:   rdata_d = pa_out;
      IX_DIRB: rdata_d = pb_dir;
      IX_DIRA: rdata_d = pa_dir;
      IX_T1CL: rdata_d = t1_cnt[7:0];
      IX_T1CH: rdata_d = t1_cnt[CW-1:HB];
      IX_T1LL: rdata_d = t1_lat[7:0];
      IX_T1LH: rdata_d = t1_lat[CW-1:HB];
      IX_T2CL: rdata_d = t2_cnt[7:0];
      IX_T2CH: rdata_d = t2_cnt[CW-1:HB];
      IX_SHFT: rdata_d = shift_q;
      IX_ACTL: rdata_d = actl_q;
      IX_PCTL: rdata_d = pctl_q;
      IX_FLAG: rdata_d = {|(flags & enables), flags};
      IX_ENAB: rdata_d = {1'b1, enables};
      IX_PANH: rdata_d = pa_out;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rdata_d;
  end

  // R10
  shift_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && ix == IX_SHFT && !wr) |=> ((flags & SHIFT_ACK) == '0));
  // R13
  read_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && ix == IX_T1CL) |=> (bus_rdata == $past(t1_cnt[7:0])));
endmodule

// File: tb/dual_timer_regs_test.sv
`timescale 1ns/1ps
module dual_timer_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0, tick_en = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pa_out, pa_dir, pb_out, pb_dir;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dual_timer_regs uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq), .pa_out(pa_out), .pa_dir(pa_dir),
    .pb_out(pb_out), .pb_dir(pb_dir));

  always @(posedge clk) rd_seen <= bus_sel && !bus_we;

  // monitor: compares each read result against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read result %02h with nothing expected", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic access(input bit we, input logic [3:0] idx, input logic [7:0] d,
                        input bit tk, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = {idx, 9'h0}; bus_wdata = d; tick_en = tk;
    if (!we) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    access(1'b1, idx, d, 1'b0, 8'h00, "");
  endtask

  task automatic rd(input logic [3:0] idx, input logic [7:0] exp, input string tag);
    access(1'b0, idx, 8'h00, 1'b0, exp, tag);
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(100_000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({7'd0, irq}, 8'h00, "R1 irq after reset");
    chk(pb_out, 8'h00, "R1 port B after reset");
    rd(4'd6, 8'hFF, "R1 T1 latch low");
    rd(4'd7, 8'hFF, "R1 T1 latch high");
    rd(4'd4, 8'hFF, "R1 T1 counter low");
    rd(4'd9, 8'hFF, "R1 T2 counter high");
    rd(4'd13, 8'h00, "R1 flags");

    // R2 port direction masking
    wr(4'd2, 8'h0F);
    wr(4'd0, 8'hAB);
    chk(pb_out, 8'h0B, "R2 port B masked write");
    rd(4'd0, 8'h0B, "R2 port B readback");
    wr(4'd2, 8'hF0);
    wr(4'd0, 8'h5C);
    rd(4'd0, 8'h5B, "R2 port B upper nibble write");
    wr(4'd3, 8'hFF);
    wr(4'd15, 8'h3C);
    rd(4'd1, 8'h3C, "R2 port A via alias index");
    chk(pa_out, 8'h3C, "R2 port A pins");

    // R3 / R4 latch and counter loading
    wr(4'd4, 8'h03);
    rd(4'd6, 8'h03, "R3 latch low via index 4");
    wr(4'd7, 8'h12);
    rd(4'd5, 8'hFF, "R3 counter untouched by index 7");
    rd(4'd7, 8'h12, "R3 latch high readback");
    wr(4'd5, 8'h00);
    rd(4'd4, 8'h03, "R4 counter loaded from latch");
    rd(4'd7, 8'h00, "R4 latch high from index 5");

    // R13 control bytes
    wr(4'd12, 8'h3E);
    rd(4'd12, 8'h3E, "R13 peripheral control readback");

    // R5 continuous mode, period latch+2
    wr(4'd11, 8'h40);
    rd(4'd11, 8'h40, "R13 aux control readback");
    wr(4'd14, 8'hC0);
    rd(4'd14, 8'hC0, "R9 enable read bit7");
    tick(3);
    chk({7'd0, irq}, 8'h00, "R5 no irq at count 0");
    tick(1);
    chk({7'd0, irq}, 8'h01, "R11 irq on underflow");
    rd(4'd13, 8'hC0, "R8 flag read with enabled pending");
    rd(4'd4, 8'hFF, "R5 counter at FFFF");
    chk({7'd0, irq}, 8'h00, "R12 low-counter read clears T1 flag");
    tick(1);
    rd(4'd4, 8'h03, "R5 reload from latch");
    tick(3);
    chk({7'd0, irq}, 8'h00, "R5 no early flag");
    tick(1);
    chk({7'd0, irq}, 8'h01, "R5 second flag after latch+2 ticks");

    // R12 collisions: set wins over clear
    wr(4'd13, 8'h40);
    chk({7'd0, irq}, 8'h00, "R12 flag write clears");
    tick(1);
    tick(3);
    access(1'b0, 4'd4, 8'h00, 1'b1, 8'h00, "R13 read returns pre-edge count");
    chk({7'd0, irq}, 8'h01, "R12 underflow beats read clear");
    wr(4'd13, 8'h40);
    chk({7'd0, irq}, 8'h00, "R12 clear before second collision");
    tick(1);
    tick(3);
    access(1'b1, 4'd13, 8'h40, 1'b1, 8'h00, "");
    chk({7'd0, irq}, 8'h01, "R12 underflow beats flag write");

    // R6 one-shot
    wr(4'd11, 8'h00);
    wr(4'd13, 8'h7F);
    wr(4'd4, 8'h01);
    wr(4'd5, 8'h00);
    tick(2);
    chk({7'd0, irq}, 8'h01, "R6 one-shot fires");
    wr(4'd13, 8'h40);
    tick(1);
    rd(4'd4, 8'hFE, "R6 no reload in one-shot");
    rd(4'd13, 8'h00, "R6 no refire");

    // R7 timer 2
    wr(4'd8, 8'h02);
    rd(4'd9, 8'hFF, "R7 latch low write leaves counter");
    wr(4'd9, 8'h00);
    wr(4'd14, 8'hA0);
    tick(2);
    chk({7'd0, irq}, 8'h00, "R7 T2 at zero no flag yet");
    tick(1);
    chk({7'd0, irq}, 8'h01, "R7 T2 underflow flag");
    rd(4'd8, 8'hFF, "R7 T2 counter at FFFF");
    chk({7'd0, irq}, 8'h00, "R12 T2 low read clears flag");
    tick(1);
    rd(4'd8, 8'hFE, "R7 T2 keeps counting");

    // R9 enables
    wr(4'd14, 8'h40);
    rd(4'd14, 8'hA0, "R9 enable clear");
    wr(4'd14, 8'h84);
    rd(4'd14, 8'hA4, "R9 enable set");

    // R10 shift byte
    wr(4'd10, 8'h5A);
    chk({7'd0, irq}, 8'h01, "R10 shift write raises irq");
    rd(4'd13, 8'h84, "R10 shift flag pending");
    rd(4'd10, 8'h5A, "R10 shift byte readback");
    chk({7'd0, irq}, 8'h00, "R10 shift read clears");
    rd(4'd13, 8'h00, "R10 flags clear");

    // R8 / R11 pending but not enabled
    wr(4'd14, 8'h04);
    wr(4'd10, 8'h11);
    chk({7'd0, irq}, 8'h00, "R11 disabled flag no irq");
    rd(4'd13, 8'h04, "R8 bit7 clear when not enabled");
    wr(4'd13, 8'h04);
    rd(4'd13, 8'h00, "R12 flag write clears shift flag");

    repeat (3) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "scoreboard drained");
    finish_run();
  end
endmodule